// File: doc/BRIEF.md
# Block Transfer and Search Sequencer

This unit carries out one step of a block operation for a processor core: a memory-to-memory copy, a compare-search of memory against the accumulator, a port-to-memory input, or a memory-to-port output. Each walks upward or downward through memory. The core loads a source pointer, a destination pointer, a 16-bit counter, the accumulator and the current flag byte together with a start pulse. The unit then runs the bus requests, updates the pointers, the counter and the flags, and ends the step with a one-cycle pulse.

A repeating operation is not looped inside the unit. After each step the unit reports either that the operation is finished (`done`) or that the core must move its program counter back by two and fetch the same instruction again (`rewind`). This gives a pending interrupt a chance to be taken between iterations. The cycle cost of the step is reported with the pulse.

For the input and output kinds, the low byte of the counter is the port address. The high byte is an 8-bit iteration count.

Top module: `block_xfer_seq`

## Requirements
- R1: With `op_kind`=0 (copy), the byte read from memory at the source pointer is written to memory at the destination pointer.
- R2: The source pointer moves by +1 (`op_dec`=0) or -1 (`op_dec`=1) over the full 16 bits, with carries and borrows between the bytes. For a copy the destination pointer moves the same way. For a copy or a search the 16-bit counter drops by one, and 0x0000 becomes 0xFFFF.
- R3: Flag bits are S=7, Z=6, H=4, P/V=2, N=1, C=0. A copy clears H and N, sets P/V exactly when the new counter is nonzero, and keeps every other flag bit.
- R4: With `op_kind`=1 (search), the byte at the source pointer is compared with the accumulator. S and Z come from the 8-bit difference, H is the borrow out of bit 3, N is set, C is kept, and P/V shows a nonzero new counter. No write takes place and the destination pointer is unchanged.
- R5: With `op_kind`=2 (input), the byte read from the port at address `cnt[7:0]` is written to memory at the source pointer.
- R6: With `op_kind`=3 (output), the byte read from memory at the source pointer is written to the port at address `cnt[7:0]`.
- R7: For input and output, only `cnt[15:8]` is decremented and `cnt[7:0]` is kept. S and Z come from the new high byte. H is set when the old high byte's low nibble was 0. P/V is set when the old high byte was 0x80. N is set and C is kept.
- R8: With `op_rep`=1, the step ends in `rewind` while P/V is set (copy), while P/V is set and Z is clear (search), or while the new high counter byte is nonzero (input and output). In every other case the step ends in `done`, and it always ends in `done` when `op_rep`=0.
- R9: `done` and `rewind` never occur together and each lasts one cycle. At that pulse, `cycles` reads 16 for `done` and 21 for `rewind`.
- R10: A start pulse that arrives while a step is in progress is ignored.
- R11: After reset no request or pulse is active, and the pointer, counter, flag and cycle outputs read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one step; accepted only when idle |
| op_kind | input | 2 | 0 copy, 1 search, 2 input, 3 output |
| op_dec | input | 1 | 1 selects decrementing pointers |
| op_rep | input | 1 | 1 selects the repeating form |
| src_in | input | 16 | Source pointer loaded at start |
| dst_in | input | 16 | Destination pointer loaded at start |
| cnt_in | input | 16 | Counter loaded at start |
| acc_in | input | 8 | Accumulator for the search |
| flg_in | input | 8 | Flag byte loaded at start |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| mem_ack | input | 1 | Memory acknowledge |
| io_req | output | 1 | Port request |
| io_we | output | 1 | Port write (1) or read (0) |
| io_addr | output | 8 | Port address |
| io_wdata | output | 8 | Port write data |
| io_rdata | input | 8 | Port read data |
| io_ack | input | 1 | Port acknowledge |
| src_out | output | 16 | Current source pointer |
| dst_out | output | 16 | Current destination pointer |
| cnt_out | output | 16 | Current counter |
| flg_out | output | 8 | Current flag byte |
| done | output | 1 | Step complete, operation finished |
| rewind | output | 1 | Step complete, core must move its PC back by 2 |
| cycles | output | 5 | Cycle cost of the completed step |

## Verification
A wrong internal state shows at the ports within the same step. A stepping error appears on `src_out`, `dst_out` or `cnt_out` in the cycle of the end pulse. A wrong bus selection shows up as a write to the wrong address or port a cycle earlier. A flag or repeat-decision fault turns a `done` into a `rewind` or the reverse, and it also changes `cycles` in that same cycle. A stuck sequencer shows as a step whose pulse never comes, or as a second request after the pulse.

// File: rtl/bxs_pkg.sv
package bxs_pkg;

    typedef enum logic [1:0] {
        OP_COPY   = 2'd0,
        OP_SEARCH = 2'd1,
        OP_PIN    = 2'd2,
        OP_POUT   = 2'd3
    } op_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2,
        ST_END  = 2'd3
    } seq_state_e;

    typedef struct packed {
        op_kind_e kind;
        logic     dec;
        logic     rep;
    } op_cfg_t;

    // flag byte layout, decoded by the core
    localparam int F_S  = 7;
    localparam int F_Z  = 6;
    localparam int F_H  = 4;
    localparam int F_PV = 2;
    localparam int F_N  = 1;
    localparam int F_C  = 0;

    function automatic logic kind_is_io(op_kind_e k);
        return (k == OP_PIN) || (k == OP_POUT);
    endfunction

endpackage

// File: rtl/bxs_flag_unit.sv
module bxs_flag_unit
    import bxs_pkg::*;
#(
    parameter int DW = 8,
    localparam int CW = 2 * DW
) (
    input  op_kind_e        kind,
    input  logic            rep,
    input  logic [7:0]      flg_cur,
    input  logic [DW-1:0]   acc,
    input  logic [DW-1:0]   cmp_byte,
    input  logic [DW-1:0]   io_cnt_old,
    input  logic [CW-1:0]   cnt_next,
    output logic [7:0]      flg_next,
    output logic            cont
);
    logic [DW-1:0] diff;
    logic [DW-1:0] io_new;
    logic          cnt_nz;
    logic          go;

    always_comb begin
        diff     = acc - cmp_byte;
        io_new   = io_cnt_old - DW'(1);
        cnt_nz   = |cnt_next;
        flg_next = flg_cur;
        go       = 1'b0;
        unique case (kind)
            OP_COPY: begin
                flg_next[F_H]  = 1'b0;
                flg_next[F_N]  = 1'b0;
                flg_next[F_PV] = cnt_nz;
                go             = cnt_nz;
            end
            OP_SEARCH: begin
                flg_next[F_S]  = diff[DW-1];
                flg_next[F_Z]  = (diff == '0);
                flg_next[F_H]  = (acc[3:0] < cmp_byte[3:0]);
                flg_next[F_N]  = 1'b1;
                flg_next[F_PV] = cnt_nz;
                go             = cnt_nz && (diff != '0);
            end
            default: begin
                flg_next[F_S]  = io_new[DW-1];
                flg_next[F_Z]  = (io_new == '0);
                flg_next[F_H]  = (io_cnt_old[3:0] == 4'd0);
                flg_next[F_PV] = (io_cnt_old == {1'b1, {(DW-1){1'b0}}});
                flg_next[F_N]  = 1'b1;
                go             = (io_new != '0);
            end
        endcase
        cont = rep && go;
    end

endmodule

// File: rtl/bxs_ctrl.sv
module bxs_ctrl
    import bxs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  op_kind_e   kind,
    input  logic       mem_ack,
    input  logic       io_ack,
    output seq_state_e state,
    output logic       launch,
    output logic       capture,
    output logic       commit
);
    seq_state_e state_nx;
    logic       ack_rd;
    logic       ack_wr;

    always_comb begin
        ack_rd  = (kind == OP_PIN)  ? io_ack : mem_ack;
        ack_wr  = (kind == OP_POUT) ? io_ack : mem_ack;
        launch  = (state == ST_IDLE) && start;
        capture = (state == ST_RD) && ack_rd && (kind != OP_SEARCH);
        commit  = ((state == ST_RD) && ack_rd && (kind == OP_SEARCH))
               || ((state == ST_WR) && ack_wr);
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_RD;
            ST_RD:   if (ack_rd) state_nx = (kind == OP_SEARCH) ? ST_END : ST_WR;
            ST_WR:   if (ack_wr) state_nx = ST_END;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

endmodule

// File: rtl/block_xfer_seq.sv
module block_xfer_seq
    import bxs_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int STEP_CYC = 16,
    parameter int EXTRA_CYC = 5,
    localparam int CYC_W = $clog2(STEP_CYC + EXTRA_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        op_kind,
    input  logic              op_dec,
    input  logic              op_rep,
    input  logic [AW-1:0]     src_in,
    input  logic [AW-1:0]     dst_in,
    input  logic [2*DW-1:0]   cnt_in,
    input  logic [DW-1:0]     acc_in,
    input  logic [7:0]        flg_in,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata,
    input  logic              mem_ack,
    output logic              io_req,
    output logic              io_we,
    output logic [DW-1:0]     io_addr,
    output logic [DW-1:0]     io_wdata,
    input  logic [DW-1:0]     io_rdata,
    input  logic              io_ack,
    output logic [AW-1:0]     src_out,
    output logic [AW-1:0]     dst_out,
    output logic [2*DW-1:0]   cnt_out,
    output logic [7:0]        flg_out,
    output logic              done,
    output logic              rewind,
    output logic [CYC_W-1:0]  cycles
);
    localparam int CW = 2 * DW;

    op_cfg_t          cfg_r;
    logic [AW-1:0]    src_r, dst_r;
    logic [CW-1:0]    cnt_r;
    logic [DW-1:0]    acc_r, data_r;
    logic [7:0]       flg_r;
    logic             cont_r;
    logic [CYC_W-1:0] cyc_r;

    seq_state_e       state;
    logic             launch, capture, commit;
    logic             is_io;
    logic [AW-1:0]    src_next, dst_next;
    logic [CW-1:0]    cnt_next;
    logic [7:0]       flg_next;
    logic             cont_next;

    bxs_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .kind    (cfg_r.kind),
        .mem_ack (mem_ack),
        .io_ack  (io_ack),
        .state   (state),
        .launch  (launch),
        .capture (capture),
        .commit  (commit)
    );

    always_comb begin
        is_io    = kind_is_io(cfg_r.kind);
        src_next = cfg_r.dec ? src_r - AW'(1) : src_r + AW'(1);
        dst_next = cfg_r.dec ? dst_r - AW'(1) : dst_r + AW'(1);
        cnt_next = is_io ? {cnt_r[CW-1:DW] - DW'(1), cnt_r[DW-1:0]}
                         : cnt_r - CW'(1);
    end

    bxs_flag_unit #(.DW(DW)) u_flags (
        .kind       (cfg_r.kind),
        .rep        (cfg_r.rep),
        .flg_cur    (flg_r),
        .acc        (acc_r),
        .cmp_byte   (mem_rdata),
        .io_cnt_old (cnt_r[CW-1:DW]),
        .cnt_next   (cnt_next),
        .flg_next   (flg_next),
        .cont       (cont_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_r  <= '{kind: OP_COPY, dec: 1'b0, rep: 1'b0};
            src_r  <= '0;
            dst_r  <= '0;
            cnt_r  <= '0;
            acc_r  <= '0;
            data_r <= '0;
            flg_r  <= '0;
            cont_r <= 1'b0;
            cyc_r  <= '0;
        end else begin
            if (launch) begin
                cfg_r <= '{kind: op_kind_e'(op_kind), dec: op_dec, rep: op_rep};
                src_r <= src_in;
                dst_r <= dst_in;
                cnt_r <= cnt_in;
                acc_r <= acc_in;
                flg_r <= flg_in;
            end
            if (capture)
                data_r <= (cfg_r.kind == OP_PIN) ? io_rdata : mem_rdata;
            if (commit) begin
                src_r  <= src_next;
                if (cfg_r.kind == OP_COPY) dst_r <= dst_next;
                cnt_r  <= cnt_next;
                flg_r  <= flg_next;
                cont_r <= cont_next;
                cyc_r  <= cont_next ? CYC_W'(STEP_CYC + EXTRA_CYC) : CYC_W'(STEP_CYC);
            end
        end
    end

    always_comb begin
        mem_req   = ((state == ST_RD) && (cfg_r.kind != OP_PIN))
                 || ((state == ST_WR) && (cfg_r.kind != OP_POUT));
        mem_we    = (state == ST_WR);
        mem_addr  = ((state == ST_WR) && (cfg_r.kind == OP_COPY)) ? dst_r : src_r;
        mem_wdata = data_r;
        io_req    = ((state == ST_RD) && (cfg_r.kind == OP_PIN))
                 || ((state == ST_WR) && (cfg_r.kind == OP_POUT));
        io_we     = (state == ST_WR);
        io_addr   = cnt_r[DW-1:0];
        io_wdata  = data_r;
        done      = (state == ST_END) && !cont_r;
        rewind    = (state == ST_END) && cont_r;
    end

    assign src_out = src_r;
    assign dst_out = dst_r;
    assign cnt_out = cnt_r;
    assign flg_out = flg_r;
    assign cycles  = cyc_r;

endmodule

// File: rtl/bxs_checker.sv
module bxs_checker #(
    parameter int CW = 16,
    parameter int CYC_W = 5,
    parameter int STEP_CYC = 16,
    parameter int EXTRA_CYC = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             done,
    input logic             rewind,
    input logic             mem_req,
    input logic             io_req,
    input logic [CW-1:0]    cnt_out,
    input logic [CYC_W-1:0] cycles
);
    AST_END_EXCL: assert property (@(posedge clk) disable iff (rst) !(done && rewind)); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R9
    AST_REWIND_PULSE: assert property (@(posedge clk) disable iff (rst) rewind |=> !rewind); // R9
    AST_CYC_DONE: assert property (@(posedge clk) disable iff (rst) done |-> cycles == CYC_W'(STEP_CYC)); // R9
    AST_CYC_REWIND: assert property (@(posedge clk) disable iff (rst) rewind |-> cycles == CYC_W'(STEP_CYC + EXTRA_CYC)); // R9
    AST_QUIET_AT_END: assert property (@(posedge clk) disable iff (rst) (done || rewind) |-> !(mem_req || io_req)); // R9
    AST_REWIND_NONZERO: assert property (@(posedge clk) disable iff (rst) rewind |-> cnt_out != '0); // R8
    AST_ONE_BUS: assert property (@(posedge clk) disable iff (rst) !(mem_req && io_req)); // R5
    AST_LAUNCH_REQ: assert property (@(posedge clk) disable iff (rst)
        (start && !mem_req && !io_req && !done && !rewind) |=> (mem_req || io_req)); // R10
endmodule

bind block_xfer_seq bxs_checker #(
    .CW(2 * DW), .CYC_W(CYC_W), .STEP_CYC(STEP_CYC), .EXTRA_CYC(EXTRA_CYC)
) u_bxs_chk (
    .clk(clk), .rst(rst), .start(start), .done(done), .rewind(rewind),
    .mem_req(mem_req), .io_req(io_req), .cnt_out(cnt_out), .cycles(cycles)
);

// File: tb/block_xfer_seq_test.sv
module block_xfer_seq_test;
    localparam int CLK_P = 10;

    typedef struct packed {
        logic [1:0]  kind;
        logic        dec;
        logic        rep;
        logic [15:0] src;
        logic [15:0] dst;
        logic [15:0] cnt;
        logic [7:0]  acc;
        logic [7:0]  flg;
        logic [15:0] e_src;
        logic [15:0] e_dst;
        logic [15:0] e_cnt;
        logic [7:0]  e_flg;
        logic        e_rew;
        logic [15:0] e_waddr;
        logic [7:0]  e_wdata;
    } vec_t;

    // memory reads return addr[7:0]+0x11; port reads return port^0x5A
    localparam vec_t VECS [11] = '{
        '{2'd0,1'b0,1'b0,16'h1000,16'h2000,16'h0003,8'h00,8'h00,16'h1001,16'h2001,16'h0002,8'h04,1'b0,16'h2000,8'h11},
        '{2'd0,1'b0,1'b1,16'h10FF,16'h20FF,16'h0002,8'h00,8'hD3,16'h1100,16'h2100,16'h0001,8'hC5,1'b1,16'h20FF,8'h10},
        '{2'd0,1'b1,1'b1,16'h1100,16'h3000,16'h0001,8'h00,8'h04,16'h10FF,16'h2FFF,16'h0000,8'h00,1'b0,16'h3000,8'h11},
        '{2'd0,1'b1,1'b0,16'h0000,16'h0000,16'h0000,8'h00,8'h00,16'hFFFF,16'hFFFF,16'hFFFF,8'h04,1'b0,16'h0000,8'h11},
        '{2'd1,1'b0,1'b1,16'h0040,16'h1234,16'h0005,8'h51,8'h01,16'h0041,16'h1234,16'h0004,8'h47,1'b0,16'h0000,8'h00},
        '{2'd1,1'b1,1'b1,16'h0030,16'h5555,16'h0003,8'h20,8'h00,16'h002F,16'h5555,16'h0002,8'h96,1'b1,16'h0000,8'h00},
        '{2'd1,1'b0,1'b1,16'h0000,16'h0000,16'h0001,8'h00,8'h01,16'h0001,16'h0000,16'h0000,8'h93,1'b0,16'h0000,8'h00},
        '{2'd2,1'b0,1'b0,16'h4000,16'h0000,16'h0320,8'h00,8'h01,16'h4001,16'h0000,16'h0220,8'h03,1'b0,16'h4000,8'h7A},
        '{2'd2,1'b1,1'b1,16'h4000,16'h0000,16'h0110,8'h00,8'h04,16'h3FFF,16'h0000,16'h0010,8'h42,1'b0,16'h4000,8'h4A},
        '{2'd3,1'b0,1'b1,16'h0050,16'h0000,16'h8077,8'h00,8'h00,16'h0051,16'h0000,16'h7F77,8'h16,1'b1,16'h0077,8'h61},
        '{2'd3,1'b1,1'b0,16'h0000,16'h0000,16'h0005,8'h00,8'h41,16'hFFFF,16'h0000,16'hFF05,8'h93,1'b0,16'h0005,8'h11}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  op_kind = '0;
    logic        op_dec = 1'b0;
    logic        op_rep = 1'b0;
    logic [15:0] src_in = '0, dst_in = '0, cnt_in = '0;
    logic [7:0]  acc_in = '0, flg_in = '0;
    logic        mem_req, mem_we, io_req, io_we, mem_ack, io_ack;
    logic [15:0] mem_addr, src_out, dst_out, cnt_out;
    logic [7:0]  mem_wdata, mem_rdata, io_addr, io_wdata, io_rdata, flg_out;
    logic        done, rewind;
    logic [4:0]  cycles;

    int n_chk = 0;
    int n_fail = 0;
    int mwr_n = 0, iwr_n = 0;
    logic [15:0] mwr_a = '0;
    logic [7:0]  mwr_d = '0, iwr_a = '0, iwr_d = '0;

    always #(CLK_P/2) clk = ~clk;

    assign mem_ack   = mem_req;
    assign mem_rdata = mem_addr[7:0] + 8'h11;
    assign io_ack    = io_req;
    assign io_rdata  = io_addr ^ 8'h5A;

    always @(posedge clk) begin
        if (mem_req && mem_we) begin mwr_n <= mwr_n + 1; mwr_a <= mem_addr; mwr_d <= mem_wdata; end
        if (io_req && io_we)   begin iwr_n <= iwr_n + 1; iwr_a <= io_addr;  iwr_d <= io_wdata;  end
    end

    block_xfer_seq uut (
        .clk(clk), .rst(rst), .start(start), .op_kind(op_kind), .op_dec(op_dec), .op_rep(op_rep),
        .src_in(src_in), .dst_in(dst_in), .cnt_in(cnt_in), .acc_in(acc_in), .flg_in(flg_in),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .io_req(io_req), .io_we(io_we), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .io_ack(io_ack),
        .src_out(src_out), .dst_out(dst_out), .cnt_out(cnt_out), .flg_out(flg_out),
        .done(done), .rewind(rewind), .cycles(cycles)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic launch(input logic [1:0] k, input logic d, input logic r,
                          input logic [15:0] s, input logic [15:0] t, input logic [15:0] c,
                          input logic [7:0] a, input logic [7:0] f);
        @(negedge clk);
        mwr_n = 0; iwr_n = 0;
        op_kind = k; op_dec = d; op_rep = r;
        src_in = s; dst_in = t; cnt_in = c; acc_in = a; flg_in = f;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end(input string req);
        logic seen;
        seen = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if (done || rewind) begin seen = 1'b1; break; end
            @(negedge clk);
        end
        chk(req, "step end pulse seen", {31'd0, seen}, 32'd1);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_fail++;
        $display("FAIL watchdog all requirements: actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11", "reset mem_req", {31'd0, mem_req}, 32'd0);
        chk("R11", "reset io_req", {31'd0, io_req}, 32'd0);
        chk("R11", "reset done/rewind", {30'd0, done, rewind}, 32'd0);
        chk("R11", "reset src/dst", {src_out, dst_out}, 32'd0);
        chk("R11", "reset cnt/flags/cycles", {3'd0, cnt_out, flg_out, cycles}, 32'd0);

        foreach (VECS[i]) begin
            vec_t v;
            string fr, cr;
            v = VECS[i];
            fr = (v.kind == 2'd0) ? "R3" : (v.kind == 2'd1) ? "R4" : "R7";
            cr = (v.kind[1]) ? "R7" : "R2";
            launch(v.kind, v.dec, v.rep, v.src, v.dst, v.cnt, v.acc, v.flg);
            wait_end("R8");
            chk("R2", $sformatf("v%0d source pointer", i), {16'd0, src_out}, {16'd0, v.e_src});
            chk("R2", $sformatf("v%0d destination pointer", i), {16'd0, dst_out}, {16'd0, v.e_dst});
            chk(cr, $sformatf("v%0d counter", i), {16'd0, cnt_out}, {16'd0, v.e_cnt});
            chk(fr, $sformatf("v%0d flags", i), {24'd0, flg_out}, {24'd0, v.e_flg});
            chk("R8", $sformatf("v%0d rewind/done", i), {30'd0, rewind, done}, {30'd0, v.e_rew, !v.e_rew});
            chk("R9", $sformatf("v%0d cycles", i), {27'd0, cycles}, v.e_rew ? 32'd21 : 32'd16);
            case (v.kind)
                2'd0: begin
                    chk("R1", $sformatf("v%0d copy write", i), {8'd0, mwr_a, mwr_d}, {8'd0, v.e_waddr, v.e_wdata});
                    chk("R1", $sformatf("v%0d copy write count", i), mwr_n, 32'd1);
                end
                2'd1: begin
                    chk("R4", $sformatf("v%0d search writes", i), mwr_n + iwr_n, 32'd0);
                end
                2'd2: begin
                    chk("R5", $sformatf("v%0d input write", i), {8'd0, mwr_a, mwr_d}, {8'd0, v.e_waddr, v.e_wdata});
                    chk("R5", $sformatf("v%0d input port writes", i), iwr_n, 32'd0);
                end
                default: begin
                    chk("R6", $sformatf("v%0d output write", i), {16'd0, iwr_a, iwr_d}, {16'd0, v.e_waddr[7:0], v.e_wdata});
                    chk("R6", $sformatf("v%0d output mem writes", i), mwr_n, 32'd0);
                end
            endcase
            @(negedge clk);
            chk("R9", $sformatf("v%0d pulse lasts one cycle", i), {30'd0, done, rewind}, 32'd0);
        end

        // R10: second start during a step is ignored
        launch(2'd0, 1'b0, 1'b0, 16'h0100, 16'h0200, 16'h0009, 8'h00, 8'h00);
        op_kind = 2'd1; src_in = 16'h0700; dst_in = 16'h0800; cnt_in = 16'h0001; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_end("R10");
        chk("R10", "src after ignored start", {16'd0, src_out}, 32'h0101);
        chk("R10", "dst after ignored start", {16'd0, dst_out}, 32'h0201);
        chk("R10", "cnt after ignored start", {16'd0, cnt_out}, 32'h0008);
        chk("R10", "write after ignored start", {8'd0, mwr_a, mwr_d}, {8'd0, 16'h0200, 8'h11});
        @(negedge clk);
        chk("R10", "idle after step", {29'd0, mem_req, io_req, done}, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule